// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block is the general register file of a 16-bit processor core. It keeps eight word registers. The first four are data registers. Each of them can be reached as one 16-bit word, or as two separate bytes: the upper half is bits 15..8 and the lower half is bits 7..0. The other four registers are the stack pointer, the base pointer, the source index and the destination index. These can only be reached as whole words.

The file has two read ports and one write port. Every port takes a 3-bit register code and a flag that picks byte or word access.
- Reads are combinational.
- A write takes effect on the rising clock edge when the write enable is high.
- A byte write merges into one half of a data register and keeps the other half.
- A byte read returns the chosen half zero-extended to 16 bits.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all eight registers to 0x0000, so every read returns zero afterwards.
- R2: A word write (wr_byte=0) with code 0..7 replaces the whole 16-bit register of that index with wr_data. Indices 0..3 are the data registers and 4..7 are the stack pointer, base pointer, source index and destination index. The new value is readable after the rising edge.
- R3: A byte write with code 0..3 stores wr_data[7:0] into bits 7..0 of data register 0..3 and leaves bits 15..8 of that register unchanged. wr_data[15:8] is ignored.
- R4: A byte write with code 4..7 stores wr_data[7:0] into bits 15..8 of data register (code-4) and leaves bits 7..0 of that register unchanged.
- R5: A byte read with code 0..3 returns bits 7..0 of data register 0..3, and with code 4..7 returns bits 15..8 of data register (code-4). In both cases the result is zero-extended, so result bits 15..8 are 0.
- R6: No byte write alters any of the four pointer/index registers (word indices 4..7), and no write alters a register other than its target.
- R7: Reads are combinational and have no write-through. A read of the register being written in the same cycle returns the old value, and the new value appears only after the edge.
- R8: With wr_en low, no register changes, whatever the other write inputs carry.
- R9: The two read ports are independent. Each one returns the register chosen by its own code and byte flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_code | input | 3 | Register code for read port A |
| rd_a_byte | input | 1 | Read port A: 1 = byte access, 0 = word access |
| rd_a_data | output | 16 | Read port A data |
| rd_b_code | input | 3 | Register code for read port B |
| rd_b_byte | input | 1 | Read port B: 1 = byte access, 0 = word access |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write port: 1 = byte access, 0 = word access |
| wr_code | input | 3 | Register code for the write port |
| wr_data | input | 16 | Write data; only bits 7..0 are used for byte writes |

## Verification
The assertions assume that the write inputs hold steady from just after one rising edge until the next. They also assume that rst is applied for whole cycles, so each `$past` sample is the value the register actually stored. The bench changes every input only at the falling edge and keeps rst high for whole cycles, which meets these assumptions. During byte writes it loads the ignored upper byte of wr_data with values that differ from the lower byte. Codes 0..7 are covered in both access modes, so no encoding lies outside what the checks cover.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   // write strobes for the two byte lanes of one register
   typedef struct packed {
      logic hi;
      logic lo;
   } lane_we_t;

   typedef enum logic {
      ACC_WORD = 1'b0,
      ACC_BYTE = 1'b1
   } access_e;

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
   parameter int CODE_W = 3
) (
   input  logic                                   en,
   input  gpr_pkg::access_e                       acc,
   input  logic [CODE_W-1:0]                      code,
   output gpr_pkg::lane_we_t [(1<<CODE_W)-1:0]    lane_we
);

   localparam int NREG  = 1 << CODE_W;
   localparam int NHALF = NREG / 2;

   logic word_acc;
   logic byte_hi;
   logic [CODE_W-2:0] byte_idx;

   assign word_acc = (acc == gpr_pkg::ACC_WORD);
   assign byte_hi  = code[CODE_W-1];
   assign byte_idx = code[CODE_W-2:0];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g);
      logic word_hit;
      assign word_hit = en & word_acc & (code == MY_CODE);

      if (g < NHALF) begin : g_split
         localparam logic [CODE_W-2:0] MY_SUB = (CODE_W-1)'(g);
         logic byte_hit;
         assign byte_hit   = en & ~word_acc & (byte_idx == MY_SUB);
         assign lane_we[g] = '{hi: word_hit | (byte_hit & byte_hi),
                               lo: word_hit | (byte_hit & ~byte_hi)};
      end else begin : g_whole
         assign lane_we[g] = '{hi: word_hit, lo: word_hit};
      end
   end

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 3
) (
   input  logic                                        clk,
   input  logic                                        rst,
   input  gpr_pkg::lane_we_t [(1<<CODE_W)-1:0]         lane_we,
   input  logic [WORD_W/2-1:0]                         lo_src,
   input  logic [WORD_W/2-1:0]                         hi_src,
   output logic [(1<<CODE_W)-1:0][WORD_W-1:0]          regs_q
);

   localparam int NREG   = 1 << CODE_W;
   localparam int NHALF  = NREG / 2;
   localparam int BYTE_W = WORD_W / 2;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g < NHALF) begin : g_split
         logic [BYTE_W-1:0] lo_q;
         logic [BYTE_W-1:0] hi_q;

         always_ff @(posedge clk) begin
            if (rst)                 lo_q <= '0;
            else if (lane_we[g].lo)  lo_q <= lo_src;
         end

         always_ff @(posedge clk) begin
            if (rst)                 hi_q <= '0;
            else if (lane_we[g].hi)  hi_q <= hi_src;
         end

         assign regs_q[g] = {hi_q, lo_q};
      end else begin : g_whole
         logic [WORD_W-1:0] word_q;

         always_ff @(posedge clk) begin
            if (rst)                 word_q <= '0;
            else if (lane_we[g].lo)  word_q <= {hi_src, lo_src};
         end

         assign regs_q[g] = word_q;
      end
   end

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 3
) (
   input  logic [(1<<CODE_W)-1:0][WORD_W-1:0]   regs,
   input  logic [CODE_W-1:0]                    code,
   input  gpr_pkg::access_e                     acc,
   output logic [WORD_W-1:0]                    data
);

   localparam int BYTE_W = WORD_W / 2;

   logic [CODE_W-1:0] split_idx;
   logic [WORD_W-1:0] split_word;

   assign split_idx  = {1'b0, code[CODE_W-2:0]};
   assign split_word = regs[split_idx];

   always_comb begin
      if (acc == gpr_pkg::ACC_BYTE) begin
         data = '0;
         data[BYTE_W-1:0] = code[CODE_W-1] ? split_word[WORD_W-1:BYTE_W]
                                           : split_word[BYTE_W-1:0];
      end else begin
         data = regs[code];
      end
   end

endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CODE_W-1:0]   rd_a_code,
   input  logic                rd_a_byte,
   output logic [WORD_W-1:0]   rd_a_data,
   input  logic [CODE_W-1:0]   rd_b_code,
   input  logic                rd_b_byte,
   output logic [WORD_W-1:0]   rd_b_data,
   input  logic                wr_en,
   input  logic                wr_byte,
   input  logic [CODE_W-1:0]   wr_code,
   input  logic [WORD_W-1:0]   wr_data
);

   localparam int NREG   = 1 << CODE_W;
   localparam int BYTE_W = WORD_W / 2;
   localparam int NRD    = 2;

   if (WORD_W % 2 != 0 || WORD_W < 2) begin : g_bad_width
      $error("gpr_file: WORD_W must be even and at least 2");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("gpr_file: CODE_W must be at least 2");
   end

   gpr_pkg::lane_we_t [NREG-1:0]     lane_we;
   logic [NREG-1:0][WORD_W-1:0]      regs_q;
   logic [BYTE_W-1:0]                hi_src;
   gpr_pkg::access_e                 wr_acc;

   assign wr_acc = gpr_pkg::access_e'(wr_byte);
   // a byte write into an upper half takes its value from the low data byte
   assign hi_src = wr_byte ? wr_data[BYTE_W-1:0] : wr_data[WORD_W-1:BYTE_W];

   gpr_wr_decode #(.CODE_W(CODE_W)) i_dec (
      .en      (wr_en),
      .acc     (wr_acc),
      .code    (wr_code),
      .lane_we (lane_we)
   );

   gpr_store #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_store (
      .clk     (clk),
      .rst     (rst),
      .lane_we (lane_we),
      .lo_src  (wr_data[BYTE_W-1:0]),
      .hi_src  (hi_src),
      .regs_q  (regs_q)
   );

   logic [NRD-1:0][CODE_W-1:0] rp_code;
   logic [NRD-1:0]             rp_byte;
   logic [NRD-1:0][WORD_W-1:0] rp_data;

   assign rp_code = {rd_b_code, rd_a_code};
   assign rp_byte = {rd_b_byte, rd_a_byte};
   assign rd_a_data = rp_data[0];
   assign rd_b_data = rp_data[1];

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      gpr_rd_port #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_port (
         .regs (regs_q),
         .code (rp_code[p]),
         .acc  (gpr_pkg::access_e'(rp_byte[p])),
         .data (rp_data[p])
      );
   end

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 3
) (
   input logic                                 clk,
   input logic                                 rst,
   input logic                                 wr_en,
   input logic                                 wr_byte,
   input logic [CODE_W-1:0]                    wr_code,
   input logic [WORD_W-1:0]                    wr_data,
   input logic [CODE_W-1:0]                    rd_a_code,
   input logic                                 rd_a_byte,
   input logic [WORD_W-1:0]                    rd_a_data,
   input logic [(1<<CODE_W)-1:0][WORD_W-1:0]   regs_q
);

   localparam int NREG   = 1 << CODE_W;
   localparam int NHALF  = NREG / 2;
   localparam int BYTE_W = WORD_W / 2;

   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   // R1
   always_ff @(posedge clk) begin
      if (rst_d === 1'b1) begin
         reset_clear_chk: assert (regs_q == '0);
      end
   end

   // R2
   word_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_byte) |=> regs_q[$past(wr_code)] == $past(wr_data));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> regs_q == $past(regs_q));

   // R6
   ptr_byte_immune_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_byte) |=> regs_q[NREG-1:NHALF] == $past(regs_q[NREG-1:NHALF]));

   for (genvar g = 0; g < NHALF; g++) begin : g_half
      localparam logic [CODE_W-1:0] LO_CODE = CODE_W'(g);
      localparam logic [CODE_W-1:0] HI_CODE = CODE_W'(g + NHALF);

      // R3
      lo_merge_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_byte && wr_code == LO_CODE) |=>
            (regs_q[g][WORD_W-1:BYTE_W] == $past(regs_q[g][WORD_W-1:BYTE_W])) &&
            (regs_q[g][BYTE_W-1:0] == $past(wr_data[BYTE_W-1:0])));

      // R4
      hi_merge_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_byte && wr_code == HI_CODE) |=>
            (regs_q[g][BYTE_W-1:0] == $past(regs_q[g][BYTE_W-1:0])) &&
            (regs_q[g][WORD_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0])));
   end

   // R5
   byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
      rd_a_byte |-> rd_a_data[WORD_W-1:BYTE_W] == '0);

   // R7
   word_read_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_a_byte |-> rd_a_data == regs_q[rd_a_code]);

endmodule

bind gpr_file gpr_file_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_byte   (wr_byte),
   .wr_code   (wr_code),
   .wr_data   (wr_data),
   .rd_a_code (rd_a_code),
   .rd_a_byte (rd_a_byte),
   .rd_a_data (rd_a_data),
   .regs_q    (regs_q)
);

// File: tb/test_gpr_file.sv
`timescale 1ns/1ps
module test_gpr_file;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  rd_a_code = '0;
   logic        rd_a_byte = 1'b0;
   logic [15:0] rd_a_data;
   logic [2:0]  rd_b_code = '0;
   logic        rd_b_byte = 1'b0;
   logic [15:0] rd_b_data;
   logic        wr_en = 1'b0;
   logic        wr_byte = 1'b0;
   logic [2:0]  wr_code = '0;
   logic [15:0] wr_data = '0;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [15:0] model [8];

   always #10 clk = ~clk;

   gpr_file i_gpr_file (
      .clk(clk), .rst(rst),
      .rd_a_code(rd_a_code), .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
      .rd_b_code(rd_b_code), .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_byte(wr_byte), .wr_code(wr_code), .wr_data(wr_data)
   );

   function automatic logic [15:0] expv(input logic [2:0] c, input logic b);
      if (!b)      return model[c];
      else if (c[2]) return {8'h00, model[{1'b0, c[1:0]}][15:8]};
      else         return {8'h00, model[c][7:0]};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] c, input logic b, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_byte = b; wr_code = c; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 16'hDEAD;
      if (!b)       model[c] = d;
      else if (c[2]) model[{1'b0, c[1:0]}][15:8] = d[7:0];
      else          model[c][7:0] = d[7:0];
   endtask

   task automatic rd(input string tag, input logic [2:0] c, input logic b);
      rd_a_code = c; rd_a_byte = b;
      rd_b_code = c ^ 3'b101; rd_b_byte = ~b;
      #2;
      check({tag, " A"}, rd_a_data, expv(c, b));
      check({tag, " B"}, rd_b_data, expv(c ^ 3'b101, ~b));
   endtask

   task automatic t_reset_state;
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < 8; c++) rd("R1 reset state", 3'(c), 1'b0);
   endtask

   task automatic t_word_writes;
      for (int c = 0; c < 8; c++) wr(3'(c), 1'b0, 16'h1100 * 16'(c + 1) + 16'h0037 + 16'(c));
      for (int c = 0; c < 8; c++) rd("R2 word write", 3'(c), 1'b0);
   endtask

   task automatic t_byte_low;
      wr(3'd1, 1'b1, 16'hF0A5);
      wr(3'd3, 1'b1, 16'h9C00);
      rd("R3 low byte merge", 3'd1, 1'b0);
      rd("R3 low byte merge", 3'd3, 1'b0);
      rd("R3 neighbour", 3'd0, 1'b0);
   endtask

   task automatic t_byte_high;
      wr(3'd4, 1'b1, 16'h0F5A);
      wr(3'd6, 1'b1, 16'hAAC3);
      rd("R4 high byte merge", 3'd0, 1'b0);
      rd("R4 high byte merge", 3'd2, 1'b0);
   endtask

   task automatic t_byte_reads;
      for (int c = 0; c < 8; c++) rd("R5 byte read", 3'(c), 1'b1);
   endtask

   task automatic t_ptr_immune;
      for (int c = 4; c < 8; c++) wr(3'(c), 1'b1, 16'h7E00 + 16'(c));
      for (int c = 4; c < 8; c++) rd("R6 pointer untouched", 3'(c), 1'b0);
   endtask

   task automatic t_read_old;
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 1'b0; wr_code = 3'd5; wr_data = 16'hBEEF;
      rd_a_code = 3'd5; rd_a_byte = 1'b0;
      #2;
      check("R7 old value during write", rd_a_data, model[5]);
      @(negedge clk);
      wr_en = 1'b0;
      model[5] = 16'hBEEF;
      #2;
      check("R7 new value after edge", rd_a_data, 16'hBEEF);
   endtask

   task automatic t_idle;
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b0; wr_code = 3'd2; wr_data = 16'h5555;
      repeat (2) @(negedge clk);
      wr_byte = 1'b1; wr_code = 3'd6;
      @(negedge clk);
      for (int c = 0; c < 8; c++) rd("R8 disabled write", 3'(c), 1'b0);
   endtask

   task automatic t_dual;
      rd_a_code = 3'd7; rd_a_byte = 1'b0;
      rd_b_code = 3'd5; rd_b_byte = 1'b1;
      #2;
      check("R9 port A", rd_a_data, expv(3'd7, 1'b0));
      check("R9 port B", rd_b_data, expv(3'd5, 1'b1));
   endtask

   task automatic t_reset_again;
      wr(3'd2, 1'b0, 16'hFFFF);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 8; i++) model[i] = '0;
      for (int c = 0; c < 8; c++) rd("R1 reset clears", 3'(c), 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_word_writes();
      t_byte_low();
      t_byte_high();
      t_byte_reads();
      t_ptr_immune();
      t_read_old();
      t_idle();
      t_dual();
      t_reset_again();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule